// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital side of a successive-approximation converter. It divides the CPU clock down to an ADC clock and counts ADC clock cycles through each conversion. It pulses a sample-and-hold strobe on a falling ADC clock phase and walks a 10-bit trial code from the MSB down, keeping or dropping each bit according to a 1-bit comparator input. When the last bit is settled, it writes the right-adjusted result and raises a sticky completion flag. The analog comparator, the DAC and the reference are outside the block. The bench models them with one comparison of an input value against `dac_code`.

Software sets the start bit with a one-cycle pulse and clears the flag with a write-one pulse. There are three operating modes. In single mode, the start bit drops when the conversion finishes. In free-running mode, every completion starts the next conversion at once. In triggered mode, the rising edge of an external trigger passes through a short synchroniser and then re-phases the prescaler, which fixes the delay from trigger to sample point. The first conversion after enable runs long so that the analog side can settle. Dropping the enable aborts any conversion in progress.

Top module: `adc_seq_top`

## Requirements
- R1: The ADC clock period D, in CPU clocks, is 2 to the power `ps_sel` for `ps_sel` 1..7, and is 2 for `ps_sel` 0. The prescaler is held at its start phase while `en` is low.
- R2: When `en` and `start_set` are raised in the same cycle after a disabled period, counting that cycle's clock edge as 1, `sh_strobe` is seen 14.5·D edges later and `result_we` is seen 26·D edges later. This is the long first conversion: 25 ADC cycles, with the sample point 13.5 cycles in.
- R3: A later conversion lasts 13 ADC cycles. `sh_strobe` appears between 1.5·D+2 and 2.5·D+1 edges after the start pulse, because the conversion waits for the next rising ADC edge and samples 1.5 cycles after it. `result_we` follows `sh_strobe` by exactly 11.5·D clocks.
- R4: Bits are decided MSB first, one per ADC cycle. A decided bit is kept when `cmp_in` is 1, which means the input is at least `dac_code`. `result[9:0]` holds the final code and `result[15:10]` is zero.
- R5: `result_we` and the rising edge of `flag` occur in the same cycle. In `mode` 0 (single) and `mode` 2 (triggered), `start_bit` is low from that cycle on. `mode` 3 behaves as single.
- R6: `flag` stays high until a `flag_clr` pulse. A completion in the same cycle as the clear leaves it set.
- R7: In `mode` 1 (free running), `start_bit` stays high and consecutive `result_we` pulses are exactly 13·D clocks apart.
- R8: In `mode` 2, with the block idle, a rising edge on `trig_in` raised just before clock edge 1 produces `sh_strobe` at edge 2·D+3. That is three CPU clocks of synchronisation followed by two ADC cycles.
- R9: A trigger held high starts only one conversion. A trigger edge that arrives while a conversion is running is ignored.
- R10: When `en` goes low, `busy` and `start_bit` are low on the next clock and no `result_we` follows. The next conversion after re-enable is the long one of R2.
- R11: A `start_set` pulse while `en` is low has no effect: `start_bit` and `busy` stay low.
- R12: After reset, `start_bit`, `busy`, `flag`, `result_we`, `sh_strobe`, `bit_strobe` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; low aborts and re-arms the long conversion |
| mode | input | 2 | 0 single, 1 free running, 2 triggered, 3 single |
| ps_sel | input | 3 | Prescaler select, D = 2^ps_sel (minimum 2) |
| start_set | input | 1 | One-cycle software write of the start bit |
| trig_in | input | 1 | Trigger source, asynchronous |
| flag_clr | input | 1 | One-cycle write-one-to-clear of the flag |
| cmp_in | input | 1 | Comparator: 1 when the input is at least `dac_code` |
| start_bit | output | 1 | Start bit as read back by software |
| busy | output | 1 | Conversion in progress |
| sh_strobe | output | 1 | One-cycle sample-and-hold pulse |
| bit_strobe | output | 1 | One-cycle pulse per decided result bit |
| dac_code | output | 10 | Trial code for the DAC |
| flag | output | 1 | Sticky completion flag |
| result_we | output | 1 | One-cycle result register write |
| result | output | 16 | Right-adjusted conversion result |

## Verification
The bench builds the block with its default parameters: 10 result bits, sample points at ADC cycles 2 and 14, a 3-bit prescaler select and a two-stage trigger synchroniser. By varying `ps_sel` across 0, 1, 2, 3 and 7, the bench exercises dividers of 2, 4, 8 and 128. This shows that the half-cycle sample point and the exact 13- and 25-cycle lengths scale with D, including the smallest divider, where the rising and falling ticks are one clock apart. The dividers of 2 and 4 also give trigger-to-sample counts short enough to pin to a single clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } adc_mode_e;
endpackage

// File: rtl/adc_seq_prescaler.sv
// Divides the CPU clock; emits one-clock rising and falling ADC-clock ticks.
module adc_seq_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             resync,
  output logic             tick_rise,
  output logic             tick_fall
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   div_full;
  logic [CNT_W-1:0] div_m1;
  logic [CNT_W-1:0] half;
  logic [SEL_W-1:0] eff;

  always_comb begin
    eff      = (sel == '0) ? SEL_W'(1) : sel;
    div_full = (CNT_W+1)'(1) << eff;
    div_m1   = CNT_W'(div_full - 1'b1);
    half     = CNT_W'(div_full >> 1);
  end

  // A trigger re-phases the count to mid-period so the next rising tick is half a period away.
  always_ff @(posedge clk) begin
    if (rst || !en)           cnt <= '0;
    else if (resync)          cnt <= half;
    else if (cnt >= div_m1)   cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick_rise = en && (cnt == div_m1);
  assign tick_fall = en && (cnt == half - 1'b1);
endmodule

// File: rtl/adc_seq_trig_sync.sv
// Synchronises the trigger and turns its rising edge into a one-clock event.
module adc_seq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic evt
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign evt = chain[STAGES-1] && !prev;
endmodule

// File: rtl/adc_seq_core.sv
// ADC-cycle counter, sample point, and successive-approximation register.
module adc_seq_core #(
  parameter int RES_W      = 10,
  parameter int SAMP_NORM  = 2,
  parameter int SAMP_FIRST = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise,
  input  logic             fall,
  input  logic             start_req,
  input  logic             restart,
  input  logic             cmp,
  output logic             busy,
  output logic             done,
  output logic             sh_pulse,
  output logic             bit_pulse,
  output logic [RES_W-1:0] trial
);
  localparam int LEN_NORM  = SAMP_NORM + RES_W + 1;
  localparam int LEN_FIRST = SAMP_FIRST + RES_W + 1;
  localparam int CYC_W     = $clog2(LEN_FIRST + 1);

  logic [CYC_W-1:0] cyc;
  logic [CYC_W-1:0] samp_pt;
  logic [CYC_W-1:0] conv_len;
  logic             long_r;
  logic             first_pend;
  logic             begin_conv;
  logic [RES_W-1:0] trial_nxt;
  int               idx_i;

  always_comb begin
    samp_pt    = long_r ? CYC_W'(SAMP_FIRST) : CYC_W'(SAMP_NORM);
    conv_len   = long_r ? CYC_W'(LEN_FIRST)  : CYC_W'(LEN_NORM);
    done       = en && rise && (cyc == conv_len);
    sh_pulse   = en && fall && (cyc == samp_pt);
    bit_pulse  = en && rise && (cyc > samp_pt) && (int'(cyc) <= int'(samp_pt) + RES_W);
    begin_conv = en && rise && start_req && ((cyc == '0) || (done && restart));
    idx_i      = RES_W - (int'(cyc) - int'(samp_pt));
    trial_nxt  = trial;
    for (int b = 0; b < RES_W; b++) begin
      if (b == idx_i && !cmp) trial_nxt[b] = 1'b0;
      if (b + 1 == idx_i)     trial_nxt[b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc        <= '0;
      long_r     <= 1'b0;
      first_pend <= 1'b1;
      trial      <= '0;
    end else if (!en) begin
      cyc        <= '0;
      first_pend <= 1'b1;
    end else begin
      if (begin_conv) begin
        cyc        <= CYC_W'(1);
        long_r     <= first_pend;
        first_pend <= 1'b0;
      end else if (done) begin
        cyc <= '0;
      end else if (rise && cyc != '0) begin
        cyc <= cyc + 1'b1;
      end
      if (sh_pulse)       trial <= RES_W'(1) << (RES_W - 1);
      else if (bit_pulse) trial <= trial_nxt;
    end
  end

  assign busy = (cyc != '0);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SAMP_NORM   = 2,
  parameter int SAMP_FIRST  = 14,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int OUT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] ps_sel,
  input  logic             start_set,
  input  logic             trig_in,
  input  logic             flag_clr,
  input  logic             cmp_in,
  output logic             start_bit,
  output logic             busy,
  output logic             sh_strobe,
  output logic             bit_strobe,
  output logic [RES_W-1:0] dac_code,
  output logic             flag,
  output logic             result_we,
  output logic [OUT_W-1:0] result
);
  adc_mode_e mode_e;
  logic      tick_rise, tick_fall, trig_evt, resync;
  logic      done, sh_pulse, bit_pulse;

  assign mode_e = adc_mode_e'(mode);
  assign resync = en && (mode_e == MODE_AUTO) && trig_evt && !start_bit && !busy;

  adc_seq_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst(rst), .en(en), .sel(ps_sel), .resync(resync),
    .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  adc_seq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(trig_in), .evt(trig_evt)
  );

  adc_seq_core #(.RES_W(RES_W), .SAMP_NORM(SAMP_NORM), .SAMP_FIRST(SAMP_FIRST)) u_core (
    .clk(clk), .rst(rst), .en(en), .rise(tick_rise), .fall(tick_fall),
    .start_req(start_bit), .restart(mode_e == MODE_FREE), .cmp(cmp_in),
    .busy(busy), .done(done), .sh_pulse(sh_pulse), .bit_pulse(bit_pulse),
    .trial(dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_bit  <= 1'b0;
      flag       <= 1'b0;
      result_we  <= 1'b0;
      sh_strobe  <= 1'b0;
      bit_strobe <= 1'b0;
      result     <= '0;
    end else begin
      result_we  <= done;
      sh_strobe  <= sh_pulse;
      bit_strobe <= bit_pulse;
      if (done) result <= OUT_W'(dac_code);
      flag <= done || (flag && !flag_clr);
      if (!en)                               start_bit <= 1'b0;
      else if (done && mode_e != MODE_FREE)  start_bit <= 1'b0;
      else if (start_set || resync)          start_bit <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [1:0] mode,
  input logic       flag_clr,
  input logic       start_bit,
  input logic       busy,
  input logic       flag,
  input logic       result_we,
  input logic       sh_strobe,
  input logic       bit_strobe
);
  p_flag_with_write_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> result_we);

  p_single_clears_start_r5: assert property (@(posedge clk) disable iff (rst)
    (result_we && $past(mode) != 2'd1) |-> !start_bit);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  p_free_keeps_start_r7: assert property (@(posedge clk) disable iff (rst)
    (result_we && $past(mode) == 2'd1) |-> start_bit);

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && !start_bit));

  p_write_needs_conv_r10: assert property (@(posedge clk) disable iff (rst)
    result_we |-> $past(busy) && $past(en));

  p_strobes_apart_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sh_strobe, bit_strobe, result_we}));
endmodule

bind adc_seq_top adc_seq_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .mode(mode), .flag_clr(flag_clr),
  .start_bit(start_bit), .busy(busy), .flag(flag), .result_we(result_we),
  .sh_strobe(sh_strobe), .bit_strobe(bit_strobe)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst, en, start_set, trig_in, flag_clr, cmp_in;
  logic [1:0]  mode;
  logic [2:0]  ps_sel;
  logic        start_bit, busy, sh_strobe, bit_strobe, flag, result_we;
  logic [9:0]  dac_code, vin;
  logic [15:0] result;
  int          n_chk = 0, n_bad = 0, we_cnt = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_seq_top u_dut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .ps_sel(ps_sel),
    .start_set(start_set), .trig_in(trig_in), .flag_clr(flag_clr), .cmp_in(cmp_in),
    .start_bit(start_bit), .busy(busy), .sh_strobe(sh_strobe), .bit_strobe(bit_strobe),
    .dac_code(dac_code), .flag(flag), .result_we(result_we), .result(result)
  );

  always @(negedge clk) if (result_we) we_cnt++;

  // {ps_sel, input value}: single conversions after the first
  localparam logic [12:0] VEC [0:7] = '{
    {3'd1, 10'd0},   {3'd2, 10'd1023}, {3'd3, 10'd512}, {3'd7, 10'd511},
    {3'd1, 10'd341}, {3'd2, 10'd682},  {3'd0, 10'd1},   {3'd3, 10'd900}
  };

  function automatic int div_of(input logic [2:0] s);
    return (s == 3'd0) ? 2 : (1 << s);
  endfunction

  function automatic logic pick(input int w);
    case (w)
      0:       return sh_strobe;
      1:       return result_we;
      default: return bit_strobe;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // counts rising edges until the chosen output is seen; ends one-cycle input pulses
  task automatic wait_sig(input int w, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk); start_set = 1'b0; flag_clr = 1'b0;
    end while (!pick(w) && n < 6000);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got 200000 cycles expected fewer");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n1, n2, d, w0;
    rst = 1'b1; en = 1'b0; start_set = 1'b0; trig_in = 1'b0; flag_clr = 1'b0;
    mode = 2'd0; ps_sel = 3'd2; vin = 10'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12 reset state
    chk({start_bit, busy, flag, result_we, sh_strobe, bit_strobe} == 6'd0 && result == 16'd0,
        "R12 reset outputs", {26'd0, start_bit, busy, flag, result_we, sh_strobe, bit_strobe}, 0);

    // R11 start ignored while disabled
    start_set = 1'b1; idle(1); start_set = 1'b0; idle(20);
    chk(!start_bit && !busy, "R11 start while disabled", {start_bit, busy}, 0);

    // R2 long first conversion, D=4
    vin = 10'd777; en = 1'b1; start_set = 1'b1;
    wait_sig(0, n1); wait_sig(1, n2);
    chk(n1 == 58, "R2 first sample edge", n1, 58);
    chk(n1 + n2 == 104, "R2 first result edge", n1 + n2, 104);
    chk(result == 16'd777, "R4 first result", result, 777);
    chk(flag && !start_bit, "R5 flag set, start cleared", {flag, start_bit}, 2);

    // R6 sticky flag and clear
    idle(10);
    chk(flag, "R6 flag holds", flag, 1);
    flag_clr = 1'b1; idle(1); flag_clr = 1'b0; idle(1);
    chk(!flag, "R6 flag cleared", flag, 0);

    // Table walk: single conversions, R1/R3/R4
    for (int i = 0; i < 8; i++) begin
      ps_sel = VEC[i][12:10]; vin = VEC[i][9:0]; d = div_of(ps_sel);
      idle(3);
      start_set = 1'b1;
      wait_sig(0, n1); wait_sig(1, n2);
      chk(n1 >= 3 * d / 2 + 2 && n1 <= 5 * d / 2 + 1, "R3 start to sample", n1, 3 * d / 2 + 2);
      chk(n2 == 23 * d / 2, "R1 R3 sample to write", n2, 23 * d / 2);
      chk(result == {6'd0, VEC[i][9:0]}, "R4 result code", result, VEC[i][9:0]);
      chk(flag && !start_bit, "R5 completion", {flag, start_bit}, 2);
      flag_clr = 1'b1; idle(1); flag_clr = 1'b0;
    end

    // R7 free running, D=4
    ps_sel = 3'd2; vin = 10'd300; mode = 2'd1; idle(3);
    start_set = 1'b1;
    wait_sig(1, n1);
    wait_sig(1, n2);
    chk(n2 == 52, "R7 free-run interval", n2, 52);
    chk(start_bit, "R7 start stays high", start_bit, 1);
    chk(result == 16'd300, "R4 free-run result", result, 300);
    mode = 2'd0;
    wait_sig(1, n2);
    chk(n2 == 52 && !start_bit, "R5 leaving free run clears start", {n2, start_bit}, 104);

    // R8 trigger to sample, D=4 and D=2
    mode = 2'd2; idle(20);
    trig_in = 1'b1;
    wait_sig(0, n1);
    chk(n1 == 11, "R8 trigger to sample D4", n1, 11);
    w0 = we_cnt;
    idle(300);
    chk(we_cnt - w0 == 1, "R9 held trigger one conversion", we_cnt - w0, 1);
    chk(!start_bit && !busy, "R5 triggered completion clears start", start_bit, 0);
    trig_in = 1'b0; ps_sel = 3'd1; idle(10);
    trig_in = 1'b1;
    wait_sig(0, n1);
    chk(n1 == 7, "R8 trigger to sample D2", n1, 7);
    w0 = we_cnt;
    trig_in = 1'b0; idle(3); trig_in = 1'b1;
    idle(200);
    chk(we_cnt - w0 == 1, "R9 trigger while busy ignored", we_cnt - w0, 1);
    trig_in = 1'b0;

    // R10 abort, then long conversion again at D=2
    mode = 2'd0; ps_sel = 3'd0; vin = 10'd42; idle(5);
    flag_clr = 1'b1; idle(1); flag_clr = 1'b0;
    start_set = 1'b1; idle(1); start_set = 1'b0; idle(10);
    chk(busy, "R10 conversion running before abort", busy, 1);
    en = 1'b0; idle(1);
    chk(!busy && !start_bit, "R10 abort", {busy, start_bit}, 0);
    w0 = we_cnt; idle(100);
    chk(we_cnt == w0 && !flag, "R10 no write after abort", we_cnt - w0, 0);
    en = 1'b1; start_set = 1'b1;
    wait_sig(0, n1); wait_sig(1, n2);
    chk(n1 == 29, "R10 R2 long sample after re-enable", n1, 29);
    chk(n1 + n2 == 52, "R10 R2 long result after re-enable", n1 + n2, 52);
    chk(result == 16'd42, "R4 result after re-enable", result, 42);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule